// File: doc/BRIEF.md
# Serial ID Write Sequencer

This block is the host side of a two-wire serial programming link: one clock output and one data line that the host drives or releases. After a single start pulse it plays a fixed script of thirteen frames. Each frame is a 4-bit command followed by a 16-bit payload. The script writes an 8-byte identification area in the target device. It first sends eight core-instruction frames. Two of these clear the configuration-space select and set write enable. The other six load the three bytes of the table pointer with the area's base address 200000h. Next come four data-write frames. The first three write two bytes each and advance the pointer. The fourth writes the last two bytes and starts programming. A final no-op frame releases the data line and stretches one clock-high phase for the programming time. The block then pulses done.

The eight ID bytes are taken from a 64-bit input at the moment the start pulse is accepted. Byte n is `id_bytes_i[8n+7:8n]` and is stored at address 200000h+n. Each bit lasts 2×`HALF_CYC` system cycles. New data is placed on the line as the clock rises, so the target samples it on the falling edge.

States: `ST_IDLE` waits for start. `ST_CLK_HI` is the clock-high half of a bit. `ST_CLK_LO` is the clock-low half. `ST_PROG_HOLD` holds the clock high with the data line released. `ST_DONE` is the one-cycle completion state. The transitions are:
- idle→high when start is seen.
- high→low when the half period ends.
- high→hold at the end of the high half of the last frame's fourth command bit.
- hold→low when the hold count ends.
- low→high for the next bit or the next frame.
- low→done after the 20th bit of the last frame.
- done→idle always.

Top module: `sisq_top`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, `sclk_o`, `sdat_o`, `sdat_oe_o` and `done_o` are all 0.
- R2: A start seen in idle makes the clock high on the next cycle. Every bit is `HALF_CYC` cycles with the clock high followed by `HALF_CYC` cycles low. The data value changes only in the cycle where the clock rises.
- R3: Each frame sends 20 bits: the 4 command bits and then the 16 payload bits, each field least-significant bit first.
- R4: Frames 0 to 7 use command 0000 (core instruction) with payloads 9CA6, 84A6, 0E20, 6EF8, 0E00, 6EF7, 0E00 and 6EF6, in that order.
- R5: Frames 8, 9 and 10 use command 1101 (write two bytes, pointer plus 2). Frame 11 uses command 1111 (write two bytes, start programming). Frame 8+i carries payload {byte 2i+1, byte 2i}, so the low byte is shifted first.
- R6: Frame 12 is command 0000 with payload 0000. At its fourth command bit the clock stays high for `HALF_CYC`+`HOLD_CYC` cycles. During the last `HOLD_CYC` of those cycles the data enable is 0.
- R7: `done_o` is 1 for exactly one cycle. That cycle directly follows the final clock-low half of frame 12. The block is idle on the next cycle.
- R8: A start that arrives while a sequence is running, including the done cycle, has no effect on the output stream.
- R9: The data enable is 1 in every bit phase outside the programming hold, and `sdat_o` is 0 whenever the enable is 0.
- R10: The ID bytes are captured when start is accepted. Later changes to `id_bytes_i` do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising clock edge |
| id_bytes_i | input | 64 | Eight ID bytes, byte n in bits 8n+7:8n |
| sclk_o | output | 1 | Serial programming clock |
| sdat_o | output | 1 | Serial data value |
| sdat_oe_o | output | 1 | Data drive enable (0 = line released) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All outputs are decoded from registered state, so every output changes one cycle after the edge that samples a start. The bench model relies on fixed offsets from that edge:
- The first clock-high cycle comes 1 cycle after start.
- Each later half bit comes `HALF_CYC` cycles after the one before it.
- The hold phase lasts `HOLD_CYC` cycles.
- `done_o` follows 1 cycle after the final low half.

When a start is accepted, the bench model queues one expected output tuple for every cycle of the run. It pops one tuple per rising edge and compares all four outputs on the falling edge. An off-by-one in any phase length, frame order or bit order therefore shows up as a mismatch in the exact cycle where it occurs.

// File: rtl/sisq_pkg.sv
package sisq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_PROG_HOLD,
        ST_DONE
    } seq_state_e;

    localparam int CMD_BITS    = 4;
    localparam int PAY_BITS    = 16;
    localparam int FRAME_BITS  = CMD_BITS + PAY_BITS;
    localparam int NUM_FRAMES  = 13;
    localparam int LAST_FRAME  = NUM_FRAMES - 1;
    localparam int FIRST_WRITE = 8;
    localparam int HOLD_BIT    = CMD_BITS - 1;
    localparam int FIDX_W      = $clog2(NUM_FRAMES);
    localparam int BIDX_W      = $clog2(FRAME_BITS);

    localparam logic [CMD_BITS-1:0] CMD_CORE   = 4'b0000;
    localparam logic [CMD_BITS-1:0] CMD_WR_INC = 4'b1101;
    localparam logic [CMD_BITS-1:0] CMD_WR_GO  = 4'b1111;

    // Returns {payload, command}; bit 0 is the first bit on the wire.
    function automatic logic [FRAME_BITS-1:0] frame_word(
        input logic [FIDX_W-1:0] idx,
        input logic [63:0]       bytes
    );
        logic [CMD_BITS-1:0] cmd;
        logic [PAY_BITS-1:0] pay;
        logic [1:0]          pair;
        cmd  = CMD_CORE;
        pay  = '0;
        pair = 2'(idx - FIDX_W'(FIRST_WRITE));
        unique case (idx)
            4'd0:  pay = 16'h9CA6;   // clear config-space select
            4'd1:  pay = 16'h84A6;   // set write enable
            4'd2:  pay = 16'h0E20;   // literal upper pointer byte
            4'd3:  pay = 16'h6EF8;   // move to upper pointer
            4'd4:  pay = 16'h0E00;
            4'd5:  pay = 16'h6EF7;   // move to high pointer
            4'd6:  pay = 16'h0E00;
            4'd7:  pay = 16'h6EF6;   // move to low pointer
            4'd8, 4'd9, 4'd10: begin
                cmd = CMD_WR_INC;
                pay = bytes[{pair, 4'b0000} +: 16];
            end
            4'd11: begin
                cmd = CMD_WR_GO;
                pay = bytes[{pair, 4'b0000} +: 16];
            end
            default: begin
                cmd = CMD_CORE;      // closing no-op
                pay = '0;
            end
        endcase
        return {pay, cmd};
    endfunction

endpackage

// File: rtl/sisq_script.sv
module sisq_script
    import sisq_pkg::*;
(
    input  logic [FIDX_W-1:0] frame_idx_i,
    input  logic [BIDX_W-1:0] bit_idx_i,
    input  logic [63:0]       bytes_i,
    output logic              bit_o,
    output logic              last_bit_o,
    output logic              last_frame_o,
    output logic              hold_point_o
);

    logic [FRAME_BITS-1:0] word;

    always_comb begin
        word         = frame_word(frame_idx_i, bytes_i);
        bit_o        = word[bit_idx_i];
        last_bit_o   = (bit_idx_i == BIDX_W'(FRAME_BITS - 1));
        last_frame_o = (frame_idx_i == FIDX_W'(LAST_FRAME));
        hold_point_o = last_frame_o && (bit_idx_i == BIDX_W'(HOLD_BIT));
    end

endmodule

// File: rtl/sisq_timer.sv
module sisq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sisq_top.sv
module sisq_top
    import sisq_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int HOLD_CYC = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] id_bytes_i,
    output logic        sclk_o,
    output logic        sdat_o,
    output logic        sdat_oe_o,
    output logic        done_o
);

    localparam int MAX_CNT = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
    localparam int TW      = $clog2(MAX_CNT + 1);
    localparam logic [TW-1:0] HALF_LOAD = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] HOLD_LOAD = TW'(HOLD_CYC - 1);

    seq_state_e         state_q, state_d;
    logic [FIDX_W-1:0]  frame_q, frame_d;
    logic [BIDX_W-1:0]  bit_q, bit_d;
    logic [63:0]        bytes_q, bytes_d;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_zero;
    logic               cur_bit, last_bit, last_frame, hold_point;

    sisq_script u_script (
        .frame_idx_i  (frame_q),
        .bit_idx_i    (bit_q),
        .bytes_i      (bytes_q),
        .bit_o        (cur_bit),
        .last_bit_o   (last_bit),
        .last_frame_o (last_frame),
        .hold_point_o (hold_point)
    );

    sisq_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            bit_q   <= '0;
            bytes_q <= '0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
            bit_q   <= bit_d;
            bytes_q <= bytes_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        frame_d  = frame_q;
        bit_d    = bit_q;
        bytes_d  = bytes_q;
        tmr_load = 1'b0;
        tmr_val  = HALF_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_CLK_HI;
                    frame_d  = '0;
                    bit_d    = '0;
                    bytes_d  = id_bytes_i;
                    tmr_load = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (hold_point) begin
                        state_d = ST_PROG_HOLD;
                        tmr_val = HOLD_LOAD;
                    end else begin
                        state_d = ST_CLK_LO;
                    end
                end
            end
            ST_PROG_HOLD: begin
                if (tmr_zero) begin
                    state_d  = ST_CLK_LO;
                    tmr_load = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (tmr_zero) begin
                    if (last_bit && last_frame) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_CLK_HI;
                        tmr_load = 1'b1;
                        if (last_bit) begin
                            frame_d = frame_q + 1'b1;
                            bit_d   = '0;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sclk_o    = 1'b0;
        sdat_oe_o = 1'b0;
        sdat_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_CLK_HI: begin
                sclk_o    = 1'b1;
                sdat_oe_o = 1'b1;
                sdat_o    = cur_bit;
            end
            ST_CLK_LO: begin
                sdat_oe_o = 1'b1;
                sdat_o    = cur_bit;
            end
            ST_PROG_HOLD: sclk_o = 1'b1;
            ST_DONE:      done_o = 1'b1;
            default: ;
        endcase
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !sclk_o && !sdat_oe_o));

    a_r9_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sdat_oe_o |-> !sdat_o);

    a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sdat_oe_o && $past(sdat_oe_o) && !$stable(sdat_o)) |-> $rose(sclk_o));

    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && frame_q != '0 && state_q != ST_IDLE && state_q != ST_DONE)
        |=> (frame_q != '0));

    a_r6_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_HOLD) |=> (state_q == ST_PROG_HOLD || state_q == ST_CLK_LO));

    a_r10_bytes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(bytes_q));

endmodule

// File: tb/tb_sisq_top.sv
module tb_sisq_top;

    localparam int HALF = 2;
    localparam int HOLD = 200;

    typedef struct {
        logic  sclk;
        logic  sdat;
        logic  oe;
        logic  done;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] idb = '0;
    logic        sclk, sdat, oe, done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    exp_t q[$];
    exp_t cur;

    sisq_top #(.HALF_CYC(HALF), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .id_bytes_i(idb),
        .sclk_o(sclk), .sdat_o(sdat), .sdat_oe_o(oe), .done_o(done)
    );

    always #5 clk = ~clk;

    function automatic exp_t mk(logic c, logic d, logic e, logic dn, string t);
        exp_t x;
        x.sclk = c; x.sdat = d; x.oe = e; x.done = dn; x.tag = t;
        return x;
    endfunction

    task automatic push_run(input logic [63:0] b);
        logic [15:0] core [8] = '{16'h9CA6, 16'h84A6, 16'h0E20, 16'h6EF8,
                                  16'h0E00, 16'h6EF7, 16'h0E00, 16'h6EF6};
        for (int f = 0; f < 13; f++) begin
            logic [3:0]  c;
            logic [15:0] p;
            string       t;
            if (f < 8) begin
                c = 4'b0000; p = core[f]; t = "R2 R3 R4";
            end else if (f < 12) begin
                c = (f == 11) ? 4'b1111 : 4'b1101;
                p = {b[8*(2*(f-8)+1) +: 8], b[8*(2*(f-8)) +: 8]};
                t = "R3 R5 R10";
            end else begin
                c = 4'b0000; p = 16'h0000; t = "R6 R9";
            end
            for (int k = 0; k < 20; k++) begin
                logic bv;
                bv = (k < 4) ? c[k] : p[k-4];
                for (int h = 0; h < HALF; h++) q.push_back(mk(1'b1, bv, 1'b1, 1'b0, t));
                if (f == 12 && k == 3)
                    for (int h = 0; h < HOLD; h++) q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, "R6"));
                for (int h = 0; h < HALF; h++) q.push_back(mk(1'b0, bv, 1'b1, 1'b0, t));
            end
        end
        q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b1, "R7"));
    endtask

    // Reference model: one expected tuple per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            cur = mk(1'b0, 1'b0, 1'b0, 1'b0, "R1 R8");
        end else begin
            if (q.size() == 0 && !cur.done && start) push_run(idb);
            if (q.size() != 0) cur = q.pop_front();
            else cur = mk(1'b0, 1'b0, 1'b0, 1'b0, "R1 R8");
        end
    end

    always @(negedge clk) begin
        cyc++;
        n_cmp++;
        if ({sclk, sdat, oe, done} !== {cur.sclk, cur.sdat, cur.oe, cur.done}) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got sclk/sdat/oe/done=%b%b%b%b expected %b%b%b%b",
                     cur.tag, cyc, sclk, sdat, oe, done, cur.sclk, cur.sdat, cur.oe, cur.done);
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        step(2);
        while (q.size() != 0 || cur.done) step(1);
        step(1);
    endtask

    initial begin
        // R1: reset state
        #2;
        n_cmp++;
        if ({sclk, sdat, oe, done} !== 4'b0000) begin
            n_bad++;
            $display("FAIL R1 in reset: got %b%b%b%b expected 0000", sclk, sdat, oe, done);
        end
        step(3);
        rst_n = 1'b1;
        step(5);

        // Run 1, busy start pulses (R8), id change mid-run (R10)
        idb = 64'h8877_6655_4433_2211;
        start = 1'b1; step(1); start = 1'b0;
        step(37);
        start = 1'b1; step(1); start = 1'b0;
        idb = 64'hDEAD_BEEF_0BAD_F00D;
        step(500);
        start = 1'b1; step(3); start = 1'b0;
        wait_idle();

        // Start held high: back-to-back runs, start during done ignored (R8, R7)
        idb = 64'h0123_4567_89AB_CDEF;
        start = 1'b1;
        step(1400);
        start = 1'b0;
        wait_idle();

        // Reset mid-run returns to idle (R1)
        idb = 64'hA5A5_5A5A_FF00_00FF;
        start = 1'b1; step(1); start = 1'b0;
        step(300);
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        step(4);

        // Run with all-ones bytes (R5)
        idb = '1;
        start = 1'b1; step(1); start = 1'b0;
        wait_idle();

        // Run with all-zero bytes (R5)
        idb = '0;
        start = 1'b1; step(1); start = 1'b0;
        wait_idle();
        step(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule